// File: doc/BRIEF.md
# Segmented Multi-Region Capture Buffer

This block records a sample stream into one memory that is cut into equal regions, and each region is a ring buffer for one trigger event. Samples go into the active region and the offset wraps at the region's top back to that region's own base, so the region always holds the most recent history before a trigger. When a trigger arrives, a programmable number of further samples is stored in the same region. The capture of that event then closes: the offset of the oldest sample in the window goes into a small per-event start table, the completed-region count goes up by one, and writing moves to offset zero of the next region.

Software reads the sample memory and the start table through two read ports. It uses each event's start offset to unwind the ring into time order. A second trigger that arrives while the post-trigger samples of an earlier one are still being stored does not open a new event. It only sets a sticky flag in that event's table entry, and software sorts out such cases. Once every region holds an event, the block stops writing and raises a full flag. It stays there until the arm input restarts it at region zero.

Top module: `seg_capture`

## Requirements
- R1: After reset, the completed-region count is 0, the full flag is low, and capture runs in region 0 at offset 0.
- R2: Each accepted sample (smp_valid high, full low, arm low) is written at address {region, offset}, with the region in the upper REG_W bits. The offset then goes up by one and wraps from RSIZE-1 to 0 inside the same region.
- R3: A trigger seen with an accepted sample is itself stored, followed by post_len further accepted samples in the same region. The event closes on the write of the last of these. With post_len 0 it closes on the trigger sample.
- R4: When an event closes, table entry [region] receives the offset that follows the last write, which is the oldest sample of the window. The entry is readable on tbl_start combinationally from tbl_idx.
- R5: The completed-region count rises by one in the cycle in which the table entry is written. The next accepted sample goes to offset 0 of the following region.
- R6: After the last region closes, the full flag is high and the count equals the number of regions. From then on samples are not written and triggers have no effect.
- R7: A high arm input clears the count, the full flag, the region and the offset to 0 and ends any post-trigger phase. It takes priority over a sample in the same cycle, which is not written.
- R8: A trigger with an accepted sample during the post-trigger phase does not start a new event. It sets tbl_ovl of the current event's entry to 1. Entries of events without such a trigger read 0.
- R9: rd_data returns the memory word at rd_addr one clock after rd_addr is presented.
- R10: While smp_valid is low, nothing is written, the offset does not move, and trig is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Restart at region 0, clearing the count and the full flag |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | DW | Sample value |
| trig | input | 1 | Trigger, only taken together with smp_valid |
| post_len | input | OFF_W | Number of samples stored after the trigger sample |
| rd_addr | input | REG_W+OFF_W | Sample memory read address {region, offset} |
| rd_data | output | DW | Registered sample memory read data |
| tbl_idx | input | REG_W | Start table entry to read |
| tbl_start | output | OFF_W | Offset of the oldest sample of that event |
| tbl_ovl | output | 1 | A second trigger arrived during that event's post-trigger phase |
| regions_done | output | REG_W+1 | Number of completed regions |
| full | output | 1 | All regions hold an event and capture has stopped |

## Verification
The properties take for granted that arm, smp_valid and trig are clean synchronous levels with no unknowns once reset is released. They also assume post_len matters only in the cycle a trigger is taken, so a change between events is harmless. The bench changes every input only at the falling edge and sets post_len once per run phase. It mixes long random runs, which fill every region and keep triggering after the full flag rises, with directed cases: post_len 0, back-to-back triggers and an arm in the middle of a post-trigger phase.

// File: rtl/segcap_pkg.sv
package segcap_pkg;
  typedef enum logic {
    ST_PRE  = 1'b0,
    ST_POST = 1'b1
  } cap_state_e;
endpackage

// File: rtl/segcap_ctrl.sv
module segcap_ctrl
  import segcap_pkg::*;
#(
  parameter int OFF_W = 4,
  parameter int REG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic                   smp_valid,
  input  logic                   trig,
  input  logic [OFF_W-1:0]       post_len,
  output logic                   wr_en,
  output logic [REG_W+OFF_W-1:0] wr_addr,
  output logic                   done,
  output logic [REG_W-1:0]       done_idx,
  output logic [OFF_W-1:0]       done_start,
  output logic                   done_ovl,
  output logic [REG_W:0]         regions_done,
  output logic                   full
);
  localparam int CNT_W = REG_W + 1;

  cap_state_e       st_q, st_n;
  logic [OFF_W-1:0] off_q, off_n;
  logic [OFF_W-1:0] post_q, post_n;
  logic [REG_W-1:0] rgn_q, rgn_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ovl_q, ovl_n;
  logic             full_q, full_n;

  logic             take;
  logic             fin;
  logic             ovl_hit;
  logic [OFF_W-1:0] off_inc;

  // sample acceptance and event close decode
  always_comb begin
    take    = smp_valid && !full_q && !arm;
    off_inc = off_q + 1'b1;
    ovl_hit = take && trig && (st_q == ST_POST);
    fin     = 1'b0;
    if (take) begin
      if (st_q == ST_PRE) fin = trig && (post_len == '0);
      else                fin = (post_q == OFF_W'(1));
    end
  end

  // next state
  always_comb begin
    st_n   = st_q;
    off_n  = off_q;
    post_n = post_q;
    rgn_n  = rgn_q;
    cnt_n  = cnt_q;
    ovl_n  = ovl_q;
    full_n = full_q;
    if (arm) begin
      st_n   = ST_PRE;
      off_n  = '0;
      post_n = '0;
      rgn_n  = '0;
      cnt_n  = '0;
      ovl_n  = 1'b0;
      full_n = 1'b0;
    end else if (take) begin
      off_n = off_inc;
      ovl_n = ovl_q | ovl_hit;
      if (st_q == ST_PRE && trig && post_len != '0) begin
        st_n   = ST_POST;
        post_n = post_len;
      end else if (st_q == ST_POST) begin
        post_n = post_q - 1'b1;
      end
      if (fin) begin
        st_n   = ST_PRE;
        off_n  = '0;
        ovl_n  = 1'b0;
        rgn_n  = rgn_q + 1'b1;
        cnt_n  = cnt_q + 1'b1;
        full_n = (rgn_q == '1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PRE;
      off_q  <= '0;
      post_q <= '0;
      rgn_q  <= '0;
      cnt_q  <= '0;
      ovl_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      off_q  <= off_n;
      post_q <= post_n;
      rgn_q  <= rgn_n;
      cnt_q  <= cnt_n;
      ovl_q  <= ovl_n;
      full_q <= full_n;
    end
  end

  assign wr_en        = take;
  assign wr_addr      = {rgn_q, off_q};
  assign done         = fin;
  assign done_idx     = rgn_q;
  assign done_start   = off_inc;
  assign done_ovl     = ovl_q | ovl_hit;
  assign regions_done = cnt_q;
  assign full         = full_q;
endmodule

// File: rtl/segcap_mem.sv
module segcap_mem #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/segcap_table.sv
module segcap_table #(
  parameter int OFF_W = 4,
  parameter int REG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] widx,
  input  logic [OFF_W-1:0] wstart,
  input  logic             wovl,
  input  logic [REG_W-1:0] ridx,
  output logic [OFF_W-1:0] rstart,
  output logic             rovl
);
  localparam int NREG = 1 << REG_W;

  logic [OFF_W-1:0] start_arr [NREG];
  logic             ovl_arr   [NREG];

  for (genvar e = 0; e < NREG; e++) begin : g_ent
    logic [OFF_W-1:0] start_q;
    logic             ovl_q;
    logic             hit;

    assign hit = we && (widx == REG_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= '0;
        ovl_q   <= 1'b0;
      end else if (hit) begin
        start_q <= wstart;
        ovl_q   <= wovl;
      end
    end

    assign start_arr[e] = start_q;
    assign ovl_arr[e]   = ovl_q;
  end

  assign rstart = start_arr[ridx];
  assign rovl   = ovl_arr[ridx];
endmodule

// File: rtl/seg_capture.sv
module seg_capture #(
  parameter int DW    = 8,
  parameter int OFF_W = 4,
  parameter int REG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic                   smp_valid,
  input  logic [DW-1:0]          smp_data,
  input  logic                   trig,
  input  logic [OFF_W-1:0]       post_len,
  input  logic [REG_W+OFF_W-1:0] rd_addr,
  output logic [DW-1:0]          rd_data,
  input  logic [REG_W-1:0]       tbl_idx,
  output logic [OFF_W-1:0]       tbl_start,
  output logic                   tbl_ovl,
  output logic [REG_W:0]         regions_done,
  output logic                   full
);
  localparam int AW = REG_W + OFF_W;

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic             done;
  logic [REG_W-1:0] done_idx;
  logic [OFF_W-1:0] done_start;
  logic             done_ovl;

  segcap_ctrl #(.OFF_W(OFF_W), .REG_W(REG_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .smp_valid    (smp_valid),
    .trig         (trig),
    .post_len     (post_len),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .done         (done),
    .done_idx     (done_idx),
    .done_start   (done_start),
    .done_ovl     (done_ovl),
    .regions_done (regions_done),
    .full         (full)
  );

  segcap_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (smp_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  segcap_table #(.OFF_W(OFF_W), .REG_W(REG_W)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (done),
    .widx   (done_idx),
    .wstart (done_start),
    .wovl   (done_ovl),
    .ridx   (tbl_idx),
    .rstart (tbl_start),
    .rovl   (tbl_ovl)
  );
endmodule

// File: rtl/segcap_chk.sv
module segcap_chk #(
  parameter int OFF_W = 4,
  parameter int REG_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   arm,
  input logic                   wr_en,
  input logic [REG_W+OFF_W-1:0] wr_addr,
  input logic                   done,
  input logic [REG_W-1:0]       done_idx,
  input logic [REG_W:0]         regions_done,
  input logic                   full
);
  localparam int NREG = 1 << REG_W;

  // R2: every write lands in the region matching the completed count
  p_write_in_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr[REG_W+OFF_W-1:OFF_W] == regions_done[REG_W-1:0]);

  // R2: consecutive writes in one region advance the offset by one, wrapping
  p_offset_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done) |=> (!wr_en ||
      wr_addr[OFF_W-1:0] == OFF_W'($past(wr_addr[OFF_W-1:0]) + 1'b1)));

  // R4: the table entry written is the one for the active region
  p_done_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_idx == regions_done[REG_W-1:0]);

  // R5: closing an event raises the count by exactly one
  p_done_bumps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> regions_done == (REG_W+1)'($past(regions_done) + 1'b1));

  // R5: without arm the count never moves backwards or jumps
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (regions_done == $past(regions_done) ||
              regions_done == (REG_W+1)'($past(regions_done) + 1'b1)));

  // R6: all regions closed implies full, and full blocks writes
  p_full_at_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (regions_done == (REG_W+1)'(NREG)) |-> full);

  p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);

  // R7: arm restarts with a zero count and no full flag
  p_arm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (regions_done == '0 && !full));
endmodule

bind seg_capture segcap_chk #(.OFF_W(OFF_W), .REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm          (arm),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .done         (done),
  .done_idx     (done_idx),
  .regions_done (regions_done),
  .full         (full)
);

// File: tb/seg_capture_test.sv
module seg_capture_test;
  localparam int DW    = 8;
  localparam int OFF_W = 4;
  localparam int REG_W = 2;
  localparam int AW    = REG_W + OFF_W;
  localparam int NREG  = 1 << REG_W;
  localparam int MEMD  = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             arm;
  logic             smp_valid;
  logic [DW-1:0]    smp_data;
  logic             trig;
  logic [OFF_W-1:0] post_len;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    rd_data;
  logic [REG_W-1:0] tbl_idx;
  logic [OFF_W-1:0] tbl_start;
  logic             tbl_ovl;
  logic [REG_W:0]   regions_done;
  logic             full;

  always #10 clk = ~clk;

  seg_capture #(.DW(DW), .OFF_W(OFF_W), .REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
    .smp_data(smp_data), .trig(trig), .post_len(post_len),
    .rd_addr(rd_addr), .rd_data(rd_data), .tbl_idx(tbl_idx),
    .tbl_start(tbl_start), .tbl_ovl(tbl_ovl),
    .regions_done(regions_done), .full(full)
  );

  int n_chk = 0;
  int n_bad = 0;

  // expected-state model built from the requirements
  logic [DW-1:0]    m_mem   [MEMD];
  bit               m_wr    [MEMD];
  logic [OFF_W-1:0] m_tstart[NREG];
  logic             m_tovl  [NREG];
  logic [REG_W-1:0] m_rgn;
  logic [OFF_W-1:0] m_off;
  logic [OFF_W-1:0] m_post;
  bit               m_inpost;
  bit               m_ovl;
  bit               m_full;
  int               m_count;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic model_clear();
    m_rgn = '0; m_off = '0; m_post = '0; m_inpost = 0; m_ovl = 0;
    m_full = 0; m_count = 0;
  endtask

  task automatic model_step(input logic a, input logic v, input logic t,
                            input logic [DW-1:0] d, input logic [OFF_W-1:0] pl);
    logic [OFF_W-1:0] nxt;
    bit fin;
    bit ov;
    if (a) begin
      model_clear();                     // R7
    end else if (v && !m_full) begin     // R10: nothing without valid
      m_mem[{m_rgn, m_off}] = d;
      m_wr[{m_rgn, m_off}]  = 1;
      nxt = m_off + 1'b1;
      fin = 0;
      ov  = m_ovl;
      if (!m_inpost) begin
        if (t) begin
          if (pl == 0) fin = 1;
          else begin m_inpost = 1; m_post = pl; end
        end
      end else begin
        if (t) ov = 1;                   // R8
        if (m_post == 1) fin = 1;
        else m_post = m_post - 1'b1;
      end
      if (fin) begin
        m_tstart[m_rgn] = nxt;
        m_tovl[m_rgn]   = ov;
        m_count++;
        if (m_rgn == REG_W'(NREG - 1)) m_full = 1;
        m_rgn    = m_rgn + 1'b1;
        m_off    = '0;
        m_inpost = 0;
        m_ovl    = 0;
      end else begin
        m_off = nxt;
        m_ovl = ov;
      end
    end
  endtask

  // one clock: drive at the falling edge, check at the next falling edge
  task automatic cycle(input logic a, input logic v, input logic t,
                       input logic [DW-1:0] d, input logic [OFF_W-1:0] pl);
    arm = a; smp_valid = v; trig = t; smp_data = d; post_len = pl;
    model_step(a, v, t, d, pl);
    @(posedge clk);
    @(negedge clk);
    chk("R5", "regions_done", 32'(regions_done), 32'(m_count));
    chk("R6", "full", 32'(full), 32'(m_full));
  endtask

  task automatic readback();
    arm = 0; smp_valid = 0; trig = 0;
    for (int a = 0; a < MEMD; a++) begin
      rd_addr = AW'(a);
      @(posedge clk);
      @(negedge clk);
      if (m_wr[a]) chk("R2 R9", "rd_data", 32'(rd_data), 32'(m_mem[a]));
    end
    for (int i = 0; i < NREG; i++) begin
      if (i < m_count) begin
        tbl_idx = REG_W'(i);
        #1;
        chk("R4", "tbl_start", 32'(tbl_start), 32'(m_tstart[i]));
        chk("R8", "tbl_ovl", 32'(tbl_ovl), 32'(m_tovl[i]));
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < MEMD; a++) m_wr[a] = 0;
    model_clear();
    rst_n = 0; arm = 0; smp_valid = 0; trig = 0; smp_data = '0;
    post_len = '0; rd_addr = '0; tbl_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "regions_done", 32'(regions_done), 32'd0);
    chk("R1", "full", 32'(full), 32'd0);

    // R10: triggers without valid do nothing
    repeat (4) cycle(0, 0, 1, 8'hEE, 4'd2);
    chk("R10", "regions_done", 32'(regions_done), 32'd0);

    // R3: 20 pre samples (wraps), trigger, 3 post samples
    for (int k = 0; k < 20; k++) cycle(0, 1, 0, DW'(k + 1), 4'd3);
    cycle(0, 1, 1, 8'hA0, 4'd3);
    cycle(0, 1, 0, 8'hA1, 4'd3);
    cycle(0, 1, 0, 8'hA2, 4'd3);
    chk("R3", "count before last post", 32'(regions_done), 32'd0);
    cycle(0, 1, 0, 8'hA3, 4'd3);
    chk("R3", "count after last post", 32'(regions_done), 32'd1);

    // R3: post_len 0 closes on the trigger sample
    for (int k = 0; k < 5; k++) cycle(0, 1, 0, DW'(8'h30 + k), 4'd0);
    cycle(0, 1, 1, 8'h3F, 4'd0);
    chk("R3", "post_len 0 close", 32'(regions_done), 32'd2);

    // R8: second trigger inside the post window
    for (int k = 0; k < 6; k++) cycle(0, 1, 0, DW'(8'h50 + k), 4'd5);
    cycle(0, 1, 1, 8'h60, 4'd5);
    cycle(0, 1, 0, 8'h61, 4'd5);
    cycle(0, 1, 1, 8'h62, 4'd5);
    for (int k = 0; k < 3; k++) cycle(0, 1, 0, DW'(8'h63 + k), 4'd5);
    tbl_idx = 2'd2;
    #1;
    chk("R8", "overlap flag", 32'(tbl_ovl), 32'd1);

    // R6: last region, then stimulus while full is ignored
    for (int k = 0; k < 17; k++) cycle(0, 1, 0, DW'(8'h70 + k), 4'd1);
    cycle(0, 1, 1, 8'h90, 4'd1);
    cycle(0, 1, 0, 8'h91, 4'd1);
    chk("R6", "full after last region", 32'(full), 32'd1);
    for (int k = 0; k < 10; k++) cycle(0, 1, 1, DW'(8'hC0 + k), 4'd2);
    readback();

    // R7: arm mid post phase; the arm-cycle sample is not written
    cycle(1, 1, 0, 8'h11, 4'd4);
    chk("R7", "count after arm", 32'(regions_done), 32'd0);
    chk("R7", "full after arm", 32'(full), 32'd0);
    for (int k = 0; k < 3; k++) cycle(0, 1, 0, DW'(8'hD0 + k), 4'd4);
    cycle(0, 1, 1, 8'hD8, 4'd4);
    cycle(0, 1, 0, 8'hD9, 4'd4);
    cycle(1, 1, 0, 8'hDA, 4'd4);
    chk("R7", "count after mid arm", 32'(regions_done), 32'd0);
    for (int k = 0; k < 8; k++) cycle(0, 1, (k == 2), DW'(8'hE0 + k), 4'd2);
    readback();

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      logic [OFF_W-1:0] pl;
      pl = OFF_W'($urandom % 16);
      cycle(1, 0, 0, '0, pl);
      for (int k = 0; k < 300; k++) begin
        cycle(0, ($urandom % 5) != 0, ($urandom % 22) == 0,
              DW'($urandom), pl);
      end
      readback();
    end

    summary();
  end
endmodule